// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a 64-bit free-running count that advances at a fixed nominal rate (6.144 MHz in the intended use) while it is clocked by a faster input clock whose frequency depends on the board. In each input clock it adds a fraction num/den of one count, so the average count rate is the input rate times num/den. A 12-bit remainder accumulator holds the fractional phase. Each clock it adds the numerator, and when the sum reaches the denominator it takes the denominator away and advances the count by one. The count is therefore never more than one tick from the ideal value.

Two 32-bit ratio registers hold the numerator and the denominator. A simple write-only port reaches them. Only bits [11:0] of each carry the ratio, so software may write back whatever upper fields it read elsewhere and the ratio is not disturbed. Typical settings are 64/125 for a 12 MHz input, 8/25 for 19.2 MHz, 192/625 for 20 MHz and 4/25 for 38.4 MHz. A strap input marks a fallback input clock. While it is nonzero, the fixed ratio 75/244 replaces the programmed pair, and the programmed pair stays stored for later.

A three-state controller sequences the accumulator. SYNC is entered from reset and on every phase-clear event: a ratio write, or the strap changing between zero and nonzero. SYNC holds the remainder at zero for one cycle and then moves to RUN if the effective ratio is usable (den nonzero and num not above den), or to HOLD if it is not. RUN accumulates and emits increments. HOLD freezes the count. A clear event moves RUN or HOLD back to SYNC. Otherwise RUN stays in RUN and HOLD stays in HOLD.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the count is 0, the tick output is 0, and the ratio in force is 4/25.
- R2: Once a ratio is in force, any den consecutive accumulating clocks produce exactly num increments of the count. This holds for 64/125, 768/1625, 8/25, 192/625, 384/1625, 256/1125 and 4/25.
- R3: A write with address 0x10 loads the numerator and a write with address 0x14 loads the denominator, each from write data bits [11:0]. Write data bits [31:12] have no effect. Writes to any other address change nothing and do not clear the phase.
- R4: While the strap input is nonzero, the ratio 75/244 is in force. Ratio writes made during that time are stored, and they take effect once the strap returns to zero.
- R5: A ratio write, or a change of the strap between zero and nonzero, clears the remainder. The count does not advance on that clock edge or on the next one. Accumulation restarts from zero phase on the second edge.
- R6: The tick output is 1 for exactly the cycles that follow a clock edge at which the count advanced by one.
- R7: If the denominator in force is 0, or the numerator exceeds it, the count holds and tick stays 0.
- R8: The count wraps to 0 after its all-ones value (modulo 2^CNT_W).
- R9: The count never advances by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data; ratio field in [11:0] |
| strap | input | STRAP_W (2) | Fallback-clock strap; nonzero selects 75/244 |
| count | output | CNT_W (64) | Master count value |
| tick | output | 1 | One-cycle strobe after each count advance |

## Verification
A phase-clear event can land on the same clock edge as an accumulator crossing. The clear must win, and the count must then stay frozen for one further edge. The bench provokes this with a ratio of 1/1, where every accumulating edge crosses. It rewrites the numerator with the same value, or toggles the strap, while the count is advancing. It then samples the count just before the clear edge, just after it, after the SYNC edge and after the first RUN edge, expecting the values c, c, c and c+1. Tick is sampled alongside the count and must be 0 then 1.

// File: rtl/frc_pkg.sv
package frc_pkg;

    // Controller states of the phase accumulator
    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } frc_state_e;

    // Default register geometry
    localparam int FRC_DATA_W  = 32;
    localparam int FRC_RATIO_W = 12;

endpackage

// File: rtl/frc_ratio_regs.sv
module frc_ratio_regs #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int RATIO_W  = 12,
    parameter int STRAP_W  = 2,
    parameter logic [ADDR_W-1:0] NUM_OFFS = 'h10,
    parameter logic [ADDR_W-1:0] DEN_OFFS = 'h14,
    parameter int RST_NUM  = 4,
    parameter int RST_DEN  = 25,
    parameter int FB_NUM   = 75,
    parameter int FB_DEN   = 244
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [STRAP_W-1:0] strap,
    output logic [RATIO_W-1:0] num_o,
    output logic [RATIO_W-1:0] den_o,
    output logic               ratio_ok_o,
    output logic               clr_o
);

    localparam logic [RATIO_W-1:0] FB_NUM_V  = RATIO_W'(FB_NUM);
    localparam logic [RATIO_W-1:0] FB_DEN_V  = RATIO_W'(FB_DEN);
    localparam logic [RATIO_W-1:0] RST_NUM_V = RATIO_W'(RST_NUM);
    localparam logic [RATIO_W-1:0] RST_DEN_V = RATIO_W'(RST_DEN);

    logic [RATIO_W-1:0] num_q;
    logic [RATIO_W-1:0] den_q;
    logic               fb_q;
    logic               fb_now;
    logic               hit_num;
    logic               hit_den;
    logic               unused_upper;

    assign hit_num      = wr_en && (wr_addr == NUM_OFFS);
    assign hit_den      = wr_en && (wr_addr == DEN_OFFS);
    assign fb_now       = |strap;
    assign unused_upper = ^wr_data[DATA_W-1:RATIO_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= RST_NUM_V;
            den_q <= RST_DEN_V;
            fb_q  <= 1'b0;
        end else begin
            if (hit_num) num_q <= wr_data[RATIO_W-1:0];
            if (hit_den) den_q <= wr_data[RATIO_W-1:0];
            fb_q <= fb_now;
        end
    end

    // Phase clear coincides with the edge on which the ratio in force changes
    assign clr_o      = hit_num || hit_den || (fb_now != fb_q);
    assign num_o      = fb_q ? FB_NUM_V : num_q;
    assign den_o      = fb_q ? FB_DEN_V : den_q;
    assign ratio_ok_o = (den_o != '0) && (num_o <= den_o);

    // R3
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != NUM_OFFS && wr_addr != DEN_OFFS)
            |=> ($stable(num_q) && $stable(den_q)));

    // R4
    fallback_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|strap) |=> (num_o == FB_NUM_V && den_o == FB_DEN_V));

endmodule

// File: rtl/frc_phase_acc.sv
module frc_phase_acc
    import frc_pkg::*;
#(
    parameter int RATIO_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               ratio_ok_i,
    input  logic [RATIO_W-1:0] num_i,
    input  logic [RATIO_W-1:0] den_i,
    output logic               step_o
);

    frc_state_e         state_q;
    frc_state_e         state_d;
    logic [RATIO_W-1:0] acc_q;
    logic [RATIO_W-1:0] acc_d;
    logic [RATIO_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, num_i};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: state_d = ratio_ok_i ? ST_RUN : ST_HOLD;
            ST_RUN:  state_d = ST_RUN;
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_SYNC;
        endcase
        if (clr_i) state_d = ST_SYNC;
    end

    // Outputs and remainder update
    always_comb begin
        step_o = 1'b0;
        acc_d  = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else begin
            unique case (state_q)
                ST_SYNC: acc_d = '0;
                ST_RUN: begin
                    if (sum >= {1'b0, den_i}) begin
                        step_o = 1'b1;
                        acc_d  = RATIO_W'(sum - {1'b0, den_i});
                    end else begin
                        acc_d  = RATIO_W'(sum);
                    end
                end
                ST_HOLD: acc_d = acc_q;
                default: acc_d = '0;
            endcase
        end
    end

    // R5
    clr_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !step_o);

    // R5
    clr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !step_o);

    // R7
    bad_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok_i |-> !step_o);

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (acc_q < den_i));

endmodule

// File: rtl/frc_count.sv
module frc_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o
);

    logic [CNT_W-1:0] count_q;
    logic             tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= step_i;
            if (step_i) count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;
    assign tick_o  = tick_q;

    // R6
    step_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (tick_q && count_q == $past(count_q) + CNT_W'(1)));

    // R9
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!tick_q && $stable(count_q)));

endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
    import frc_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = FRC_DATA_W,
    parameter int RATIO_W = FRC_RATIO_W,
    parameter int STRAP_W = 2,
    parameter logic [ADDR_W-1:0] NUM_OFFS = 'h10,
    parameter logic [ADDR_W-1:0] DEN_OFFS = 'h14,
    parameter int RST_NUM = 4,
    parameter int RST_DEN = 25,
    parameter int FB_NUM  = 75,
    parameter int FB_DEN  = 244
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [STRAP_W-1:0] strap,
    output logic [CNT_W-1:0]   count,
    output logic               tick
);

    logic [RATIO_W-1:0] num_eff;
    logic [RATIO_W-1:0] den_eff;
    logic               ratio_ok;
    logic               phase_clr;
    logic               step;

    frc_ratio_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .RATIO_W (RATIO_W),
        .STRAP_W (STRAP_W),
        .NUM_OFFS(NUM_OFFS),
        .DEN_OFFS(DEN_OFFS),
        .RST_NUM (RST_NUM),
        .RST_DEN (RST_DEN),
        .FB_NUM  (FB_NUM),
        .FB_DEN  (FB_DEN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .strap     (strap),
        .num_o     (num_eff),
        .den_o     (den_eff),
        .ratio_ok_o(ratio_ok),
        .clr_o     (phase_clr)
    );

    frc_phase_acc #(
        .RATIO_W(RATIO_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (phase_clr),
        .ratio_ok_i(ratio_ok),
        .num_i     (num_eff),
        .den_i     (den_eff),
        .step_o    (step)
    );

    frc_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .count_o(count),
        .tick_o (tick)
    );

endmodule

// File: tb/frac_rate_counter_test.sv
module frac_rate_counter_test;

    localparam logic [7:0] A_NUM = 8'h10;
    localparam logic [7:0] A_DEN = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  strap = '0;
    logic [63:0] count;
    logic        tick;
    logic [7:0]  count_n;
    logic        tick_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frac_rate_counter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .strap(strap), .count(count), .tick(tick)
    );

    frac_rate_counter #(.CNT_W(8)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .strap(strap), .count(count_n), .tick(tick_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure(input int n, input int d, input string req);
        logic [63:0] c0;
        wr(A_NUM, 32'(n));
        wr(A_DEN, 32'(d));
        cyc(1);
        c0 = count;
        cyc(d);
        chk(req, count - c0, 64'(n));
    endtask

    task automatic t_reset();
        logic [63:0] c0;
        @(negedge clk);
        chk("R1 reset count", count, 0);
        chk("R1 reset tick", {63'b0, tick}, 0);
        rst_n = 1'b1;
        cyc(1);
        c0 = count;
        chk("R1 count after sync edge", c0, 0);
        cyc(25);
        chk("R1 default ratio 4/25", count - c0, 4);
    endtask

    task automatic t_ratios();
        int nums [7] = '{64, 768, 8, 192, 384, 256, 4};
        int dens [7] = '{125, 1625, 25, 625, 1625, 1125, 25};
        for (int i = 0; i < 7; i++) begin
            measure(nums[i], dens[i], $sformatf("R2 ratio %0d/%0d", nums[i], dens[i]));
            // second window in a row, no clear in between
            begin
                logic [63:0] c1;
                c1 = count;
                cyc(dens[i]);
                chk("R2 repeated window", count - c1, 64'(nums[i]));
            end
        end
    endtask

    task automatic t_reg_fields();
        logic [63:0] c0;
        wr(A_NUM, 32'hFFFF_F003);
        wr(A_DEN, 32'hABCD_E00A);
        cyc(1);
        c0 = count;
        cyc(10);
        chk("R3 upper bits ignored 3/10", count - c0, 3);
        wr(A_NUM, 32'h1);
        wr(A_DEN, 32'h1);
        cyc(2);
        c0 = count;
        wr(8'h18, 32'h0);
        chk("R3 other address no clear", count - c0, 1);
        wr(8'h11, 32'h0000_0005);
        chk("R3 near address no clear", count - c0, 2);
        cyc(5);
        chk("R3 ratio untouched by other writes", count - c0, 7);
    endtask

    task automatic t_collision();
        logic [63:0] cb;
        cyc(2);
        cb = count;
        chk("R6 tick while advancing", {63'b0, tick}, 1);
        wr(A_NUM, 32'h1);
        chk("R5 no advance on clear edge", count, cb);
        chk("R6 tick low after clear edge", {63'b0, tick}, 0);
        cyc(1);
        chk("R5 no advance on sync edge", count, cb);
        cyc(1);
        chk("R5 resume after sync", count, cb + 1);
        chk("R6 tick after resume", {63'b0, tick}, 1);
        // strap toggle acts as a clear as well
        cb = count;
        strap = 2'b01;
        cyc(1);
        chk("R5 strap change clears", count, cb);
        strap = 2'b00;
        cyc(1);
        chk("R5 strap return clears", count, cb);
        cyc(1);
        chk("R5 strap clear no advance", count, cb);
        cyc(1);
        chk("R5 strap resume", count, cb + 1);
    endtask

    task automatic t_hold();
        logic [63:0] c0;
        wr(A_DEN, 32'h0);
        c0 = count;
        cyc(40);
        chk("R7 den zero holds", count, c0);
        chk("R7 tick low in hold", {63'b0, tick}, 0);
        wr(A_NUM, 32'd30);
        wr(A_DEN, 32'd25);
        cyc(40);
        chk("R7 num above den holds", count, c0);
    endtask

    task automatic t_fallback();
        logic [63:0] c0;
        measure(64, 125, "R2 before fallback");
        strap = 2'b10;
        cyc(1);
        cyc(1);
        c0 = count;
        cyc(244);
        chk("R4 fallback 75/244", count - c0, 75);
        wr(A_NUM, 32'd8);
        wr(A_DEN, 32'd25);
        cyc(1);
        c0 = count;
        cyc(244);
        chk("R4 writes stored during fallback", count - c0, 75);
        strap = 2'b00;
        cyc(1);
        cyc(1);
        c0 = count;
        cyc(25);
        chk("R4 stored ratio after strap clears", count - c0, 8);
    endtask

    task automatic t_wrap();
        logic [63:0] cw;
        int d;
        wr(A_NUM, 32'h1);
        wr(A_DEN, 32'h1);
        cyc(1);
        cw = count;
        d = 256 - int'(count_n);
        cyc(d);
        chk("R8 narrow count wraps to zero", {56'b0, count_n}, 0);
        chk("R9 one step per clock", count - cw, 64'(d));
        cyc(1);
        chk("R8 narrow count after wrap", {56'b0, count_n}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_ratios();
        t_reg_fields();
        t_collision();
        t_hold();
        t_fallback();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule